// File: doc/BRIEF.md
# Asynchronous Serial Port with Fault-Forcing Loopback

This block is a full-duplex asynchronous serial transmitter and receiver with no FIFOs. One holding register sits on each side. A software write strobe fills the transmit holding register. The transmitter moves that byte into its own shift register and sends it as a frame. The receiver rebuilds frames from the serial line and places each character, with its error flags, in a receive holding register. A read strobe clears that register. Frame shape is set by four static configuration inputs: 7 or 8 data bits, 1 or 2 stop bits, parity off or on, and even or odd parity.

A divider built on an 8-bit counter sets the bit rate. It emits one oversampling tick every `baud_div + 1` clocks, and one bit lasts 16 ticks. While the `halt` input is high the divider does not count and emits no ticks, so both the transmitter and the receiver are frozen. In loopback mode the transmitter's serial stream goes straight to the receiver. The external output is then held idle and the external input is ignored. Software can also corrupt the looped frame on purpose to exercise its error handlers: it can flip the parity bit, pull the stop bits low, or force the overrun flag.

Top module: `ser_port`

## Requirements
- R1: Each serial bit lasts exactly 16 oversampling ticks, and a tick occurs every `baud_div + 1` clock cycles, so one bit is 16*(`baud_div`+1) clocks.
- R2: The line idles high. A transmitted frame is one low start bit, then the data bits least significant first (7 bits when `cfg_len8`=0, 8 when 1), then the optional parity bit, then one high stop bit (two when `cfg_stop2`=1).
- R3: With `cfg_par_en`=1 the parity bit makes the count of ones over data plus parity even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1.
- R4: The receiver accepts a start bit only if the line is still low at the eighth tick after the falling edge is seen. A shorter low pulse produces no character.
- R5: A received character raises `rx_ready` and appears on `rx_data`. In 7-bit mode `rx_data[7]` is 0. A one-cycle `rx_rd` clears `rx_ready` and all error flags.
- R6: `err_par` is set with a character whose received parity bit disagrees with the configured parity. It is never set when parity is off.
- R7: `err_frm` is set with a character whose first stop bit samples low.
- R8: `err_ovr` is set when a character completes while `rx_ready` is still high and not being read in that cycle. `rx_data` then holds the newer character.
- R9: With `loop_en`=1 the receiver takes the transmitter's stream, `txd` stays high, and `rxd` has no effect.
- R10: In loopback with `inj_par`=1 the looped parity bit is inverted, so the character arrives with `err_par` set. With parity off the flag has no effect.
- R11: In loopback with `inj_frm`=1 the looped stop bits are driven low, so the character arrives with `err_frm` set.
- R12: In loopback with `inj_ovr`=1 every completed character sets `err_ovr`, even if `rx_ready` was clear.
- R13: While `halt` is high no tick occurs. `txd` and the receive status do not change, and a frame in flight resumes intact after release.
- R14: `tx_empty` is high after reset, goes low in the cycle after `tx_wr`, and rises again when the byte moves into the shift register. A byte written during a frame keeps `tx_empty` low until that frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt | input | 1 | Stops the bit-rate divider |
| baud_div | input | 8 | Tick period minus one, in clocks |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_stop2 | input | 1 | 1: two stop bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| loop_en | input | 1 | Internal loopback |
| inj_par | input | 1 | Invert looped parity bit |
| inj_frm | input | 1 | Force looped stop bits low |
| inj_ovr | input | 1 | Force overrun on looped characters |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to send |
| tx_empty | output | 1 | Transmit holding register empty |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_rd | input | 1 | Read strobe for the receive holding register |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | Character waiting |
| err_par | output | 1 | Parity error for the waiting character |
| err_frm | output | 1 | Framing error for the waiting character |
| err_ovr | output | 1 | A character was lost |

## Verification
The checker verifies the holding-register handshakes on every cycle. A write always empties-to-full the transmit side on the next cycle. A read without a competing completion always drops `rx_ready`. A completion always raises it, and an overrun is never shown without a waiting character. It also checks that a halted cycle changes neither the transmit line nor the receive status. Frame contents, bit timing, parity polarity, mid-bit sampling, start-glitch rejection and the effect of each injection on the received flags depend on whole frames. Only the bench's serial scenarios, in both the external and loopback paths, can show those.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial port.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package ser_pkg;

    // Transmit sequencer phases, in frame order.
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_st_e;

    // Receive sequencer phases, in frame order.
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_st_e;

endpackage

// File: rtl/ser_baud.sv
`timescale 1ns/1ps
// Bit-rate divider: emits one oversampling tick every (div + 1) clocks.
// Assumes: div is static while running; halt freezes the count and the tick.
module ser_baud #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt,
    input  logic [CW-1:0] div,
    output logic          tick
);

    logic [CW-1:0] cnt;

    // Down-counter that reloads from div when it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!halt) begin
            if (cnt == '0) begin
                cnt <= div;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign tick = !halt && (cnt == '0);

endmodule

// File: rtl/ser_tx.sv
`timescale 1ns/1ps
// Transmitter: holding register plus shift sequencer producing one frame
// per byte. Each bit lasts OS ticks. Line state changes only on ticks.
// Assumes: frame configuration is static while a frame is in flight.
module ser_tx
    import ser_pkg::*;
#(
    parameter int DW = 8,
    parameter int OS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          len8,
    input  logic          stop2,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          empty,
    output logic          line,
    output logic          is_par,
    output logic          is_stop
);

    localparam int           CW       = $clog2(OS);
    localparam int           BW       = $clog2(DW + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(OS - 1);

    tx_st_e        st;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bitn;
    logic [BW-1:0] nbits;
    logic [DW-1:0] hold;
    logic [DW-1:0] sh;
    logic [DW-1:0] mask;
    logic          full;
    logic          pbit;
    logic          second;
    logic          load;

    assign nbits = len8 ? BW'(DW) : BW'(DW - 1);
    assign mask  = len8 ? {DW{1'b1}} : {1'b0, {(DW-1){1'b1}}};
    assign load  = tick && (st == TX_IDLE) && full;
    assign empty = !full;

    // Holding register: a write fills it, a load into the shifter empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            full <= 1'b0;
        end else if (wr) begin
            hold <= wdata;
            full <= 1'b1;
        end else if (load) begin
            full <= 1'b0;
        end
    end

    // Frame sequencer: advances one bit every OS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= TX_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            sh     <= '0;
            pbit   <= 1'b0;
            second <= 1'b0;
        end else if (tick) begin
            if (st == TX_IDLE) begin
                if (full) begin
                    sh   <= hold;
                    pbit <= (^(hold & mask)) ^ par_odd;
                    st   <= TX_START;
                    cnt  <= '0;
                end
            end else if (cnt != CNT_LAST) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                case (st)
                    TX_START: begin
                        st   <= TX_DATA;
                        bitn <= '0;
                    end
                    TX_DATA: begin
                        sh <= sh >> 1;
                        if (bitn == nbits - 1'b1) begin
                            st     <= par_en ? TX_PAR : TX_STOP;
                            second <= 1'b0;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end
                    TX_PAR: begin
                        st     <= TX_STOP;
                        second <= 1'b0;
                    end
                    TX_STOP: begin
                        if (stop2 && !second) begin
                            second <= 1'b1;
                        end else begin
                            st <= TX_IDLE;
                        end
                    end
                    default: st <= TX_IDLE;
                endcase
            end
        end
    end

    // Line level and phase flags decoded from the sequencer state.
    always_comb begin
        line    = 1'b1;
        is_par  = 1'b0;
        is_stop = 1'b0;
        case (st)
            TX_START: line = 1'b0;
            TX_DATA:  line = sh[0];
            TX_PAR: begin
                line   = pbit;
                is_par = 1'b1;
            end
            TX_STOP:  is_stop = 1'b1;
            default:  line = 1'b1;
        endcase
    end

endmodule

// File: rtl/ser_rx.sv
`timescale 1ns/1ps
// Receiver: start qualification at half a bit, then one sample per bit
// at mid-bit. Pulses done at the first stop-bit sample with the character
// and its parity and framing status.
// Assumes: line is already synchronous to clk; configuration is static.
module ser_rx
    import ser_pkg::*;
#(
    parameter int DW = 8,
    parameter int OS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line,
    input  logic          len8,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          done,
    output logic [DW-1:0] dout,
    output logic          perr,
    output logic          ferr
);

    localparam int            CW       = $clog2(OS);
    localparam int            BW       = $clog2(DW + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(OS - 1);
    localparam logic [CW-1:0] CNT_HALF = CW'(OS / 2 - 1);

    rx_st_e        st;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bitn;
    logic [BW-1:0] nbits;
    logic [DW-1:0] sh;
    logic          pbit;
    logic          armed;

    assign nbits = len8 ? BW'(DW) : BW'(DW - 1);
    assign dout  = len8 ? sh : {1'b0, sh[DW-1:1]};
    assign done  = tick && (st == RX_STOP) && (cnt == CNT_LAST);
    assign ferr  = !line;
    assign perr  = par_en && (pbit != ((^dout) ^ par_odd));

    // Frame sequencer: waits for an armed falling edge, then samples mid-bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= '0;
            pbit  <= 1'b0;
            armed <= 1'b0;
        end else if (tick) begin
            case (st)
                RX_IDLE: begin
                    if (!armed) begin
                        armed <= line;
                    end else if (!line) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (cnt != CNT_HALF) begin
                        cnt <= cnt + 1'b1;
                    end else if (line) begin
                        st <= RX_IDLE;
                    end else begin
                        st   <= RX_DATA;
                        cnt  <= '0;
                        bitn <= '0;
                    end
                end
                RX_DATA: begin
                    if (cnt != CNT_LAST) begin
                        cnt <= cnt + 1'b1;
                    end else begin
                        cnt <= '0;
                        sh  <= {line, sh[DW-1:1]};
                        if (bitn == nbits - 1'b1) begin
                            st <= par_en ? RX_PAR : RX_STOP;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end
                end
                RX_PAR: begin
                    if (cnt != CNT_LAST) begin
                        cnt <= cnt + 1'b1;
                    end else begin
                        cnt  <= '0;
                        pbit <= line;
                        st   <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (cnt != CNT_LAST) begin
                        cnt <= cnt + 1'b1;
                    end else begin
                        cnt   <= '0;
                        st    <= RX_IDLE;
                        armed <= 1'b0;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ser_rx_hold.sv
`timescale 1ns/1ps
// Receive holding register with per-character error flags.
// A completed character loads it. A read clears it unless a character
// completes in the same cycle, which takes priority.
// Assumes: rd is a single-cycle strobe.
module ser_rx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] din,
    input  logic          perr,
    input  logic          ferr,
    input  logic          force_ovr,
    input  logic          rd,
    output logic [DW-1:0] data,
    output logic          ready,
    output logic          e_par,
    output logic          e_frm,
    output logic          e_ovr
);

    // Load on completion, clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            ready <= 1'b0;
            e_par <= 1'b0;
            e_frm <= 1'b0;
            e_ovr <= 1'b0;
        end else if (done) begin
            data  <= din;
            ready <= 1'b1;
            e_par <= perr;
            e_frm <= ferr;
            e_ovr <= (ready && !rd) || force_ovr;
        end else if (rd) begin
            ready <= 1'b0;
            e_par <= 1'b0;
            e_frm <= 1'b0;
            e_ovr <= 1'b0;
        end
    end

endmodule

// File: rtl/ser_port.sv
`timescale 1ns/1ps
// Serial port top: divider, transmitter, receiver and holding register,
// plus the loopback path with fault forcing.
// Assumes: rxd is asynchronous (two-stage synchronizer here); configuration
// and loopback controls change only while the line is idle.
module ser_port #(
    parameter int DW = 8,
    parameter int OS = 16,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt,
    input  logic [DIVW-1:0] baud_div,
    input  logic            cfg_len8,
    input  logic            cfg_stop2,
    input  logic            cfg_par_en,
    input  logic            cfg_par_odd,
    input  logic            loop_en,
    input  logic            inj_par,
    input  logic            inj_frm,
    input  logic            inj_ovr,
    input  logic            tx_wr,
    input  logic [DW-1:0]   tx_data,
    output logic            tx_empty,
    output logic            txd,
    input  logic            rxd,
    input  logic            rx_rd,
    output logic [DW-1:0]   rx_data,
    output logic            rx_ready,
    output logic            err_par,
    output logic            err_frm,
    output logic            err_ovr
);

    logic          tick;
    logic          tx_line;
    logic          tx_is_par;
    logic          tx_is_stop;
    logic          loop_line;
    logic          rx_line;
    logic [1:0]    rxd_sync;
    logic          rx_done;
    logic [DW-1:0] rx_char;
    logic          rx_perr;
    logic          rx_ferr;

    // Two-stage synchronizer for the external input, idling high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_sync <= 2'b11;
        end else begin
            rxd_sync <= {rxd_sync[0], rxd};
        end
    end

    assign loop_line = (tx_line ^ (inj_par & tx_is_par)) & ~(inj_frm & tx_is_stop);
    assign rx_line   = loop_en ? loop_line : rxd_sync[1];
    assign txd       = loop_en ? 1'b1 : tx_line;

    ser_baud #(.CW(DIVW)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .halt  (halt),
        .div   (baud_div),
        .tick  (tick)
    );

    ser_tx #(.DW(DW), .OS(OS)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .len8    (cfg_len8),
        .stop2   (cfg_stop2),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .wr      (tx_wr),
        .wdata   (tx_data),
        .empty   (tx_empty),
        .line    (tx_line),
        .is_par  (tx_is_par),
        .is_stop (tx_is_stop)
    );

    ser_rx #(.DW(DW), .OS(OS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .line    (rx_line),
        .len8    (cfg_len8),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .done    (rx_done),
        .dout    (rx_char),
        .perr    (rx_perr),
        .ferr    (rx_ferr)
    );

    ser_rx_hold #(.DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (rx_done),
        .din       (rx_char),
        .perr      (rx_perr),
        .ferr      (rx_ferr),
        .force_ovr (loop_en & inj_ovr),
        .rd        (rx_rd),
        .data      (rx_data),
        .ready     (rx_ready),
        .e_par     (err_par),
        .e_frm     (err_frm),
        .e_ovr     (err_ovr)
    );

endmodule

// File: rtl/ser_port_chk.sv
`timescale 1ns/1ps
// Cycle-level properties of the serial port's handshakes and halt behaviour.
// Assumes: bound to ser_port; tx_line and rx_done are its internal nets.
module ser_port_chk (
    input logic clk,
    input logic rst_n,
    input logic halt,
    input logic tx_wr,
    input logic tx_empty,
    input logic rx_rd,
    input logic rx_done,
    input logic rx_ready,
    input logic err_ovr,
    input logic tx_line
);

    // R14
    tx_wr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_empty);

    // R5
    rx_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_done) |=> !rx_ready);

    // R5
    rx_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rx_ready);

    // R8
    ovr_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovr |-> rx_ready);

    // R13
    halt_tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(tx_line));

    // R13
    halt_rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !rx_rd) |=> $stable(rx_ready));

endmodule

bind ser_port ser_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .tx_wr    (tx_wr),
    .tx_empty (tx_empty),
    .rx_rd    (rx_rd),
    .rx_done  (rx_done),
    .rx_ready (rx_ready),
    .err_ovr  (err_ovr),
    .tx_line  (tx_line)
);

// File: tb/ser_port_tb.sv
`timescale 1ns/1ps
// Bench for ser_port: loopback vector table plus directed serial scenarios.
module ser_port_tb;

    localparam int DIV  = 1;
    localparam int BITC = 16 * (DIV + 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt = 1'b0;
    logic [7:0] baud_div = 8'(DIV);
    logic       cfg_len8 = 1'b1, cfg_stop2 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       loop_en = 1'b0, inj_par = 1'b0, inj_frm = 1'b0, inj_ovr = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_empty, txd;
    logic       rxd = 1'b1;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_par, err_frm, err_ovr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ser_port u_dut (
        .clk(clk), .rst_n(rst_n), .halt(halt), .baud_div(baud_div),
        .cfg_len8(cfg_len8), .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .loop_en(loop_en), .inj_par(inj_par),
        .inj_frm(inj_frm), .inj_ovr(inj_ovr), .tx_wr(tx_wr), .tx_data(tx_data),
        .tx_empty(tx_empty), .txd(txd), .rxd(rxd), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_ready(rx_ready), .err_par(err_par),
        .err_frm(err_frm), .err_ovr(err_ovr)
    );

    // Loopback vectors: {len8, par_en, par_odd, stop2, inj_par, inj_frm, 2'b0, data}
    localparam logic [15:0] VEC [7] = '{
        {6'b100000, 2'b00, 8'h5A},
        {6'b110010, 2'b00, 8'hC3},
        {6'b011110, 2'b00, 8'h2B},
        {6'b100010, 2'b00, 8'h81},
        {6'b100001, 2'b00, 8'h3E},
        {6'b010101, 2'b00, 8'h7F},
        {6'b111000, 2'b00, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic par_of(input logic [7:0] d, input logic l8, input logic odd);
        return (^(l8 ? d : (d & 8'h7F))) ^ odd;
    endfunction

    task automatic set_cfg(input logic l8, input logic pe, input logic po, input logic s2);
        cfg_len8 = l8; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    endtask

    task automatic write_tx(input logic [7:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_data = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_ready(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (rx_ready) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic wait_txd_low(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!txd) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic put_bit(input logic b);
        rxd = b;
        repeat (BITC) @(negedge clk);
    endtask

    // Drives one frame on rxd using the current configuration.
    task automatic drive_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int nb;
        nb = cfg_len8 ? 8 : 7;
        @(negedge clk);
        put_bit(1'b0);
        for (int i = 0; i < nb; i++) put_bit(d[i]);
        if (cfg_par_en) put_bit(par_of(d, cfg_len8, cfg_par_odd) ^ bad_par);
        put_bit(!bad_stop);
        if (cfg_stop2) put_bit(!bad_stop);
        put_bit(1'b1);
    endtask

    // Captures a transmitted frame at mid-bit and compares it with the expected bit list.
    task automatic check_tx(input logic [7:0] d, input string req);
        logic [11:0] exp_v, got_v;
        int n, nb;
        bit ok;
        nb = cfg_len8 ? 8 : 7;
        exp_v = '0; got_v = '0; n = 0;
        exp_v[n++] = 1'b0;
        for (int i = 0; i < nb; i++) exp_v[n++] = d[i];
        if (cfg_par_en) exp_v[n++] = par_of(d, cfg_len8, cfg_par_odd);
        exp_v[n++] = 1'b1;
        if (cfg_stop2) exp_v[n++] = 1'b1;
        write_tx(d);
        wait_txd_low(ok);
        repeat (BITC / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            got_v[i] = txd;
            if (i != n - 1) repeat (BITC) @(negedge clk);
        end
        chk(ok && got_v == exp_v, req, int'(got_v), int'(exp_v));
        repeat (2 * BITC) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ok;
        int cnt;
        logic held;
        bit stable;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R2 idle line, R14 empty, R5 nothing waiting
        chk(txd == 1'b1, "R2 idle line after reset", txd, 1);
        chk(tx_empty == 1'b1, "R14 empty after reset", tx_empty, 1);
        chk({rx_ready, err_par, err_frm, err_ovr} == 4'b0, "R5 rx status after reset",
            {rx_ready, err_par, err_frm, err_ovr}, 0);

        // R1: start bit duration with bit0 = 1
        set_cfg(1, 0, 0, 0);
        write_tx(8'h01);
        wait_txd_low(ok);
        cnt = 0;
        while (!txd && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk(ok && cnt == BITC, "R1 start bit length in clocks", cnt, BITC);
        repeat (11 * BITC) @(negedge clk);

        // R2 / R3: frame shapes
        set_cfg(1, 0, 0, 0); check_tx(8'hA5, "R2 8N1 frame");
        set_cfg(0, 1, 0, 1); check_tx(8'h35, "R3 7E2 frame");
        set_cfg(1, 1, 1, 0); check_tx(8'h3C, "R3 8O1 frame");
        set_cfg(0, 1, 1, 0); check_tx(8'h7F, "R3 7O1 frame");

        // R14: empty flag around writes
        set_cfg(1, 0, 0, 0);
        write_tx(8'h55);
        chk(tx_empty == 1'b0, "R14 empty drops after write", tx_empty, 0);
        cnt = 0;
        while (!tx_empty && cnt < 200) begin cnt++; @(negedge clk); end
        chk(tx_empty == 1'b1, "R14 empty after load", tx_empty, 1);
        write_tx(8'hAA);
        repeat (8 * BITC) @(negedge clk);
        chk(tx_empty == 1'b0, "R14 stays full during frame", tx_empty, 0);
        repeat (24 * BITC) @(negedge clk);
        chk(tx_empty == 1'b1, "R14 empty after second load", tx_empty, 1);

        // R5: good external frame, 8E1
        set_cfg(1, 1, 0, 0);
        drive_frame(8'h3C, 0, 0);
        chk(rx_ready && rx_data == 8'h3C && !err_par && !err_frm && !err_ovr,
            "R5 good 8E1 char", {rx_ready, err_par, err_frm, err_ovr, rx_data}, {4'b1000, 8'h3C});
        read_rx();
        chk(rx_ready == 1'b0, "R5 read clears ready", rx_ready, 0);

        // R6: bad parity
        drive_frame(8'h96, 1, 0);
        chk(rx_ready && err_par && rx_data == 8'h96, "R6 parity error",
            {rx_ready, err_par, rx_data}, {2'b11, 8'h96});
        read_rx();
        chk(err_par == 1'b0, "R6 read clears parity flag", err_par, 0);

        // R7: low stop bit
        set_cfg(1, 0, 0, 0);
        drive_frame(8'h5A, 0, 1);
        chk(rx_ready && err_frm, "R7 framing error", {rx_ready, err_frm}, 3);
        read_rx();

        // R5: 7-bit character, top bit reads 0
        set_cfg(0, 0, 0, 0);
        drive_frame(8'hC3, 0, 0);
        chk(rx_ready && rx_data == 8'h43, "R5 7-bit data", rx_data, 8'h43);
        read_rx();

        // R8: overrun
        set_cfg(1, 0, 0, 0);
        drive_frame(8'h11, 0, 0);
        drive_frame(8'h22, 0, 0);
        chk(err_ovr && rx_data == 8'h22, "R8 overrun keeps newer char",
            {err_ovr, rx_data}, {1'b1, 8'h22});
        read_rx();
        chk({rx_ready, err_ovr} == 2'b00, "R8 read clears overrun", {rx_ready, err_ovr}, 0);

        // R4: short low pulse is rejected
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (20 * BITC) @(negedge clk);
        chk(rx_ready == 1'b0, "R4 glitch rejected", rx_ready, 0);

        // R9 / R10 / R11: loopback table with external rxd held low
        loop_en = 1'b1;
        rxd = 1'b0;
        foreach (VEC[k]) begin
            logic [7:0] ed;
            set_cfg(VEC[k][15], VEC[k][14], VEC[k][13], VEC[k][12]);
            inj_par = VEC[k][11];
            inj_frm = VEC[k][10];
            ed = VEC[k][15] ? VEC[k][7:0] : (VEC[k][7:0] & 8'h7F);
            write_tx(VEC[k][7:0]);
            stable = 1'b1;
            ok = 1'b0;
            for (int i = 0; i < 4000; i++) begin
                @(negedge clk);
                if (!txd) stable = 1'b0;
                if (rx_ready) begin ok = 1'b1; break; end
            end
            chk(ok && rx_data == ed, "R9 looped data", rx_data, ed);
            chk(stable, "R9 txd held high in loopback", stable, 1);
            chk(err_par == (VEC[k][14] & VEC[k][11]), "R10 injected parity", err_par,
                VEC[k][14] & VEC[k][11]);
            chk(err_frm == VEC[k][10], "R11 injected framing", err_frm, VEC[k][10]);
            read_rx();
            repeat (4 * BITC) @(negedge clk);
        end
        inj_par = 1'b0;
        inj_frm = 1'b0;
        rxd = 1'b1;

        // R12: forced overrun with ready clear
        set_cfg(1, 0, 0, 0);
        inj_ovr = 1'b1;
        chk(rx_ready == 1'b0, "R12 ready clear before", rx_ready, 0);
        write_tx(8'h5C);
        wait_ready(ok);
        chk(ok && err_ovr && rx_data == 8'h5C, "R12 forced overrun",
            {err_ovr, rx_data}, {1'b1, 8'h5C});
        read_rx();
        inj_ovr = 1'b0;
        repeat (4 * BITC) @(negedge clk);

        // R13: halt in loopback mid-frame, frame resumes intact
        write_tx(8'h96);
        repeat (3 * BITC) @(negedge clk);
        halt = 1'b1;
        stable = 1'b1;
        repeat (400) begin
            @(negedge clk);
            if (rx_ready) stable = 1'b0;
        end
        halt = 1'b0;
        chk(stable, "R13 no character during halt", stable, 1);
        wait_ready(ok);
        chk(ok && rx_data == 8'h96 && !err_frm && !err_par, "R13 frame intact after halt",
            rx_data, 8'h96);
        read_rx();
        repeat (4 * BITC) @(negedge clk);
        loop_en = 1'b0;

        // R13: external line frozen during halt
        write_tx(8'h55);
        wait_txd_low(ok);
        repeat (2 * BITC + 5) @(negedge clk);
        halt = 1'b1;
        held = txd;
        stable = 1'b1;
        repeat (300) begin
            @(negedge clk);
            if (txd !== held) stable = 1'b0;
        end
        halt = 1'b0;
        chk(ok && stable, "R13 txd frozen during halt", stable, 1);
        repeat (12 * BITC) @(negedge clk);
        chk(txd == 1'b1 && tx_empty, "R13 frame finishes after halt", {txd, tx_empty}, 3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule